// File: doc/BRIEF.md
# Two-Level Page Access Permission Checker

This block decides whether a single memory access may go ahead under paging protection. Each request carries the access kind (read or write) and the current privilege (user or supervisor). It also carries a flag that forces the request to be judged as a supervisor access, a verdict from the segment-level check, and the user-accessible and writable attribute bits from every level of the translation tables. The block merges the attribute bits across the levels. It weighs them against the privilege and a global write-protect control, and returns a registered permit bit and a two-bit fault cause.

The global write-protect control is held in a register inside the block. It is loaded through a load strobe and cleared by reset. When the control is clear, supervisor code may write read-only pages. When it is set, read-only pages are guarded against every privilege, which supports copy-on-write sharing of pages. Requests use a valid/ready handshake. A result is held until its consumer accepts it, and no further request is taken while a result is pending.

Top module: `pac_access_check`

## Requirements
- R1: After reset, rsp_valid is 0, req_ready is 1, and the write-protect control is clear, so a supervisor write to a page with every writable bit 0 is permitted.
- R2: With the write-protect control clear and no segment fault, an access judged as supervisor is permitted (cause 0) whatever the user-accessible and writable bits of any level.
- R3: A user read without segment fault is permitted when every level's user-accessible bit is 1; if any level's user-accessible bit is 0, it faults with cause 2.
- R4: A user write without segment fault faults with cause 2 when any level's user-accessible bit is 0. Otherwise it faults with cause 3 when any level's writable bit is 0, and is permitted when all those bits are 1.
- R5: With the write-protect control set, a supervisor write without segment fault faults with cause 3 when any level's writable bit is 0. Supervisor reads stay permitted.
- R6: When implicit_sup is 1, the request is judged as a supervisor access even if req_user is 1.
- R7: When seg_fault is 1, the result is cause 1 and permit 0, whatever every other request input says.
- R8: Cause encoding is 0 = allowed, 1 = segment violation, 2 = supervisor-only page reached from user, 3 = write to a read-only page. rsp_permit is 1 exactly when the cause is 0.
- R9: A request is accepted on a clock edge where req_valid and req_ready are both 1. rsp_valid rises on that edge, and rsp_valid, rsp_permit and rsp_cause hold until an edge with rsp_ready 1 clears rsp_valid. req_ready is 0 while rsp_valid is 1.
- R10: On an edge with wp_load 1, the write-protect control takes wp_value. A request accepted on that same edge is judged with the value held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_load | input | 1 | Load strobe for the write-protect control |
| wp_value | input | 1 | New write-protect control value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = current privilege is user |
| implicit_sup | input | 1 | Judge this access as supervisor |
| seg_fault | input | 1 | Segment-level check failed |
| ent_user | input | LEVELS | User-accessible bit per table level |
| ent_write | input | LEVELS | Writable bit per table level |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_permit | output | 1 | Access allowed |
| rsp_cause | output | 2 | Fault cause code |

## Verification
The bench sweeps every combination of access kind, privilege, override flag, segment verdict, per-level attribute bits and write-protect setting for a two-level configuration. A user access with only one level's user bit cleared separates merging by AND from trusting a single level. Cases that clear the user and writable bits together show whether the privilege cause wins over the read-only cause. Supervisor writes to read-only pages, run with the control both clear and set, separate the two write-protect behaviours. User requests with the override set show that the forced supervisor judgment is applied. Some results are held with rsp_ready low, and one request is sent on the same edge as a control load, to check result holding and the ordering of the control update.

// File: rtl/pac_pkg.sv
package pac_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE   = 2'd0,
      CAUSE_SEG    = 2'd1,
      CAUSE_PRIV   = 2'd2,
      CAUSE_RDONLY = 2'd3
   } pac_cause_e;

   typedef struct packed {
      logic       permit;
      pac_cause_e cause;
   } pac_verdict_t;

endpackage

// File: rtl/pac_attr_merge.sv
module pac_attr_merge #(
   parameter int LEVELS = 2
) (
   input  logic [LEVELS-1:0] lvl_user,
   input  logic [LEVELS-1:0] lvl_write,
   output logic              eff_user,
   output logic              eff_write
);

   generate
      if (LEVELS == 1) begin : g_single
         assign eff_user  = lvl_user[0];
         assign eff_write = lvl_write[0];
      end else begin : g_chain
         logic [LEVELS-1:0] user_acc;
         logic [LEVELS-1:0] write_acc;
         assign user_acc[0]  = lvl_user[0];
         assign write_acc[0] = lvl_write[0];
         for (genvar k = 1; k < LEVELS; k++) begin : g_lvl
            assign user_acc[k]  = user_acc[k-1]  & lvl_user[k];
            assign write_acc[k] = write_acc[k-1] & lvl_write[k];
         end
         assign eff_user  = user_acc[LEVELS-1];
         assign eff_write = write_acc[LEVELS-1];
      end
   endgenerate

endmodule

// File: rtl/pac_wp_ctl.sv
module pac_wp_ctl #(
   parameter bit RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic value,
   output logic wp_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)     wp_q <= RESET_VAL;
      else if (load)  wp_q <= value;
   end

   p_wp_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (wp_q == $past(value)));

   p_wp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(wp_q));

endmodule

// File: rtl/pac_rule.sv
module pac_rule
   import pac_pkg::*;
(
   input  logic         is_write,
   input  logic         is_user,
   input  logic         force_sup,
   input  logic         seg_bad,
   input  logic         eff_user,
   input  logic         eff_write,
   input  logic         wp,
   output pac_verdict_t verdict
);

   logic judged_user;
   logic priv_bad;
   logic ro_bad;

   always_comb begin
      judged_user = is_user & ~force_sup;
      priv_bad    = judged_user & ~eff_user;
      ro_bad      = is_write & ~eff_write & (judged_user | wp);
      if (seg_bad)       verdict.cause = CAUSE_SEG;
      else if (priv_bad) verdict.cause = CAUSE_PRIV;
      else if (ro_bad)   verdict.cause = CAUSE_RDONLY;
      else               verdict.cause = CAUSE_NONE;
      verdict.permit = ~(seg_bad | priv_bad | ro_bad);
   end

endmodule

// File: rtl/pac_access_check.sv
module pac_access_check
   import pac_pkg::*;
#(
   parameter int LEVELS    = 2,
   parameter bit WP_RESET  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_load,
   input  logic              wp_value,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_user,
   input  logic              implicit_sup,
   input  logic              seg_fault,
   input  logic [LEVELS-1:0] ent_user,
   input  logic [LEVELS-1:0] ent_write,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic              rsp_permit,
   output logic [1:0]        rsp_cause
);

   localparam int MAX_LEVELS = 8;

   generate
      if (LEVELS < 1 || LEVELS > MAX_LEVELS) begin : g_bad_levels
         $error("pac_access_check: LEVELS out of range");
      end
      if (WP_RESET != 1'b0) begin : g_bad_reset
         $error("pac_access_check: write-protect control must reset clear");
      end
   endgenerate

   logic         wp_q;
   logic         eff_user;
   logic         eff_write;
   logic         accept;
   pac_verdict_t verdict_d;
   pac_verdict_t verdict_q;
   logic         valid_q;

   pac_wp_ctl #(.RESET_VAL(WP_RESET)) u_wp (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (wp_load),
      .value (wp_value),
      .wp_q  (wp_q)
   );

   pac_attr_merge #(.LEVELS(LEVELS)) u_merge (
      .lvl_user  (ent_user),
      .lvl_write (ent_write),
      .eff_user  (eff_user),
      .eff_write (eff_write)
   );

   pac_rule u_rule (
      .is_write  (req_write),
      .is_user   (req_user),
      .force_sup (implicit_sup),
      .seg_bad   (seg_fault),
      .eff_user  (eff_user),
      .eff_write (eff_write),
      .wp        (wp_q),
      .verdict   (verdict_d)
   );

   assign req_ready = ~valid_q;
   assign accept    = req_valid & req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q   <= 1'b0;
         verdict_q <= '{permit: 1'b0, cause: CAUSE_NONE};
      end else if (accept) begin
         valid_q   <= 1'b1;
         verdict_q <= verdict_d;
      end else if (rsp_ready) begin
         valid_q   <= 1'b0;
      end
   end

   assign rsp_valid  = valid_q;
   assign rsp_permit = verdict_q.permit;
   assign rsp_cause  = verdict_q.cause;

   p_no_accept_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   p_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_permit) && $stable(rsp_cause)));

   p_seg_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && seg_fault) |=> (rsp_cause == CAUSE_SEG && !rsp_permit));

   p_permit_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_permit == (rsp_cause == CAUSE_NONE)));

   p_sup_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !seg_fault && !wp_q && (!req_user || implicit_sup)) |=> rsp_permit);

endmodule

// File: tb/tb_pac_access_check.sv
module tb_pac_access_check;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wp_load, wp_value;
   logic       req_valid, req_ready;
   logic       req_write, req_user, implicit_sup, seg_fault;
   logic [1:0] ent_user, ent_write;
   logic       rsp_valid, rsp_ready, rsp_permit;
   logic [1:0] rsp_cause;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   pac_access_check #(.LEVELS(2)) dut (
      .clk(clk), .rst_n(rst_n), .wp_load(wp_load), .wp_value(wp_value),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_user(req_user), .implicit_sup(implicit_sup), .seg_fault(seg_fault),
      .ent_user(ent_user), .ent_write(ent_write), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_permit(rsp_permit), .rsp_cause(rsp_cause)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic set_wp(input logic v);
      @(negedge clk);
      wp_load = 1'b1; wp_value = v;
      @(negedge clk);
      wp_load = 1'b0;
   endtask

   task automatic do_req(input logic wr, input logic usr, input logic imp,
                         input logic seg, input logic [1:0] us, input logic [1:0] rw,
                         input bit stall, input string tag, input int exp_cause);
      @(negedge clk);
      chk(req_ready == 1'b1, "R9", "ready before request", int'(req_ready), 1);
      req_valid = 1'b1; req_write = wr; req_user = usr; implicit_sup = imp;
      seg_fault = seg; ent_user = us; ent_write = rw; rsp_ready = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid == 1'b1, "R9", "valid after accept", int'(rsp_valid), 1);
      chk(req_ready == 1'b0, "R9", "ready while pending", int'(req_ready), 0);
      chk(int'(rsp_cause) == exp_cause, tag, "cause", int'(rsp_cause), exp_cause);
      chk(rsp_permit == (exp_cause == 0), "R8", "permit", int'(rsp_permit),
          int'(exp_cause == 0));
      if (stall) begin
         @(negedge clk);
         chk(rsp_valid == 1'b1 && int'(rsp_cause) == exp_cause, "R9", "held result",
             int'(rsp_cause), exp_cause);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R9", "valid cleared", int'(rsp_valid), 0);
      rsp_ready = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic cur_wp;
      rst_n = 1'b0; wp_load = 1'b0; wp_value = 1'b0; req_valid = 1'b0;
      req_write = 1'b0; req_user = 1'b0; implicit_sup = 1'b0; seg_fault = 1'b0;
      ent_user = 2'b00; ent_write = 2'b00; rsp_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(rsp_valid == 1'b0, "R1", "valid after reset", int'(rsp_valid), 0);
      chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
      do_req(1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 2'b00, 1'b0, "R1", 0);

      // exhaustive sweep: R2 R3 R4 R5 R6 R7
      cur_wp = 1'b0;
      for (int i = 0; i < 512; i++) begin
         logic wp, wr, usr, imp, seg, ju;
         logic [1:0] us, rw;
         int exp;
         string tag;
         wp = i[0]; wr = i[1]; usr = i[2]; imp = i[3]; seg = i[4];
         us = i[6:5]; rw = i[8:7];
         if (wp != cur_wp) begin
            set_wp(wp);
            cur_wp = wp;
         end
         ju = usr & ~imp;
         if (seg) exp = 1;
         else if (ju && us != 2'b11) exp = 2;
         else if (wr && rw != 2'b11 && (ju || wp)) exp = 3;
         else exp = 0;
         if (seg) tag = "R7";
         else if (usr && imp) tag = "R6";
         else if (ju && wr) tag = "R4";
         else if (ju) tag = "R3";
         else if (wp) tag = "R5";
         else tag = "R2";
         do_req(wr, usr, imp, seg, us, rw, (i % 3) == 0, tag, exp);
      end

      // R10: load on the same edge as an accepted request
      set_wp(1'b0);
      @(negedge clk);
      wp_load = 1'b1; wp_value = 1'b1;
      req_valid = 1'b1; req_write = 1'b1; req_user = 1'b0; implicit_sup = 1'b0;
      seg_fault = 1'b0; ent_user = 2'b11; ent_write = 2'b01;
      @(negedge clk);
      wp_load = 1'b0; req_valid = 1'b0;
      chk(rsp_valid && int'(rsp_cause) == 0, "R10", "old control used",
          int'(rsp_cause), 0);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      do_req(1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 2'b01, 1'b0, "R10", 3);
      set_wp(1'b0);
      do_req(1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 2'b01, 1'b0, "R10", 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule